// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic unit of a 32-bit integer datapath. In one step it executes any of sixteen data-processing operations on two operands: the first-register operand and the operand that has already passed through the barrel shifter. The operations are bitwise logic, moves, additions, subtractions, reverse subtractions, carry-chained forms of these, and four test/compare forms. It also produces the next values of the negative, zero, carry and overflow flags.

The caller decodes the instruction and supplies the operation code, the flag-update request, both operands, the shifter's carry-out and the current flags. One clock later the block presents the result, an enable for writing the destination register, the next flags and an enable for updating the flag register. Condition evaluation, register writeback and the status register itself stay outside the block.

Top module: `dp_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register clears: `result`, `flags_out` and both enables read zero after that edge.
- R2: Each output reflects the inputs present at the previous rising clock edge, so the latency is exactly one cycle.
- R3: Opcode 0 gives rn AND op, opcode 1 gives rn XOR op, opcode 12 gives rn OR op and opcode 14 gives rn AND NOT op.
- R4: Opcode 13 passes op through and opcode 15 gives NOT op. Both ignore `rn_val`.
- R5: Opcode 4 gives rn + op and opcode 5 gives rn + op + C, where C is `flags_in[1]`.
- R6: Each subtract is x + NOT y + cin. Opcode 2 uses x=rn, y=op, cin=1. Opcode 3 uses x=op, y=rn, cin=1. Opcode 6 uses x=rn, y=op, cin=C. Opcode 7 uses x=op, y=rn, cin=C.
- R7: Opcodes 8 to 11 (bit-test AND, bit-test XOR, compare as rn+NOT op+1, compare-negated as rn+op) never raise `rd_write`. They always raise `flags_write`, whatever `set_flags` is. Every other opcode raises `rd_write`.
- R8: When flags are updated, N (`flags_out[3]`) equals the result MSB and Z (`flags_out[2]`) is set exactly when the result is zero.
- R9: For arithmetic opcodes (2 to 7, 10, 11), C (`flags_out[1]`) is the carry out of the adder MSB, so a subtract without borrow sets C.
- R10: For arithmetic opcodes, V (`flags_out[0]`) is set when both adder inputs share a sign and the sum's sign differs from it.
- R11: For logical opcodes (0, 1, 8, 9, 12 to 15), C takes `shift_carry` and V keeps `flags_in[0]`.
- R12: With `set_flags` low on an opcode outside 8 to 11, `flags_write` is low and `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 4 | Operation code, 0 to 15 |
| set_flags | input | 1 | Request to update flags |
| rn_val | input | DATA_W | First-register operand |
| shift_val | input | DATA_W | Shifted second operand |
| shift_carry | input | 1 | Carry-out of the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | DATA_W | Operation result |
| rd_write | output | 1 | Destination write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| flags_write | output | 1 | Flag register update enable |

## Verification
The adder's carry/overflow generation and the flag bypass for a cleared `set_flags` meet in the same cycle. A sum can carry or overflow while the flags must still pass through untouched, or must still be forced on because the opcode is a compare. The bench uses a 4-bit operand width to provoke this. It sweeps every opcode against every operand pair, both incoming carry values, both `set_flags` values and both shifter carries. It compares every output against values computed arithmetically from the requirements. Cases where carry, overflow or a zero result coincide with a suppressed update are covered by that sweep and judged one cycle after the inputs.

// File: rtl/dp_alu_pkg.sv
// Shared opcode encoding and flag layout for the data-processing ALU.
// Assumes the caller has already extracted the 4-bit operation field.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    // True for operations whose result comes from the adder
    function automatic logic op_is_arith(input alu_op_e op);
        case (op)
            OP_SUB, OP_RSB, OP_ADD, OP_ADC,
            OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    // True for test and compare operations (opcodes 8..11)
    function automatic logic op_is_compare(input alu_op_e op);
        return (op[3:2] == 2'b10);
    endfunction

endpackage

// File: rtl/dp_alu_operands.sv
// Operand steering: picks the adder inputs and carry-in for each arithmetic
// operation and computes the bitwise result for each logical operation.
// Assumes the carry flag input is the current C flag.
module dp_alu_operands
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] rn,
    input  logic [DATA_W-1:0] opnd,
    input  logic              c_flag,
    output logic [DATA_W-1:0] add_x,
    output logic [DATA_W-1:0] add_y,
    output logic              add_cin,
    output logic [DATA_W-1:0] logic_res
);

    // Adder input selection: subtracts invert one side, reverse forms swap
    always_comb begin
        add_x   = rn;
        add_y   = opnd;
        add_cin = 1'b0;
        case (op)
            OP_SUB, OP_CMP: begin add_x = rn;   add_y = ~opnd; add_cin = 1'b1;   end
            OP_RSB:         begin add_x = opnd; add_y = ~rn;   add_cin = 1'b1;   end
            OP_ADC:         begin add_x = rn;   add_y = opnd;  add_cin = c_flag; end
            OP_SBC:         begin add_x = rn;   add_y = ~opnd; add_cin = c_flag; end
            OP_RSC:         begin add_x = opnd; add_y = ~rn;   add_cin = c_flag; end
            default:        begin add_x = rn;   add_y = opnd;  add_cin = 1'b0;   end
        endcase
    end

    // Bitwise operations; moves ignore the first operand
    always_comb begin
        case (op)
            OP_AND, OP_TST: logic_res = rn & opnd;
            OP_EOR, OP_TEQ: logic_res = rn ^ opnd;
            OP_ORR:         logic_res = rn | opnd;
            OP_MOV:         logic_res = opnd;
            OP_BIC:         logic_res = rn & ~opnd;
            OP_MVN:         logic_res = ~opnd;
            default:        logic_res = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu_adder.sv
// Single carry-propagate adder shared by all arithmetic operations.
// Produces the sum, the carry out of the MSB and signed overflow.
module dp_alu_adder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    // Extended-width addition yields the carry directly
    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        sum  = wide[MSB:0];
        cout = wide[DATA_W];
        ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end

endmodule

// File: rtl/dp_alu_flags.sv
// Next-flag generation. Compares always update; other operations update only
// when requested. Logical operations take C from the shifter and keep V.
module dp_alu_flags
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic              set_req,
    input  logic [DATA_W-1:0] res,
    input  logic              add_cout,
    input  logic              add_ovf,
    input  logic              sh_carry,
    input  alu_flags_t        cur,
    output alu_flags_t        nxt,
    output logic              upd
);

    // Flag computation with pass-through when no update is made
    always_comb begin
        upd = set_req || op_is_compare(op);
        nxt = cur;
        if (upd) begin
            nxt.n = res[DATA_W-1];
            nxt.z = (res == '0);
            if (op_is_arith(op)) begin
                nxt.c = add_cout;
                nxt.v = add_ovf;
            end else begin
                nxt.c = sh_carry;
                nxt.v = cur.v;
            end
        end
    end

endmodule

// File: rtl/dp_alu.sv
// Data-processing ALU top: combines operand steering, the adder and flag
// logic, then registers all outputs (one-cycle latency).
// Assumes a synchronous active-low reset and flags ordered {N,Z,C,V}.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        opcode,
    input  logic              set_flags,
    input  logic [DATA_W-1:0] rn_val,
    input  logic [DATA_W-1:0] shift_val,
    input  logic              shift_carry,
    input  logic [3:0]        flags_in,
    output logic [DATA_W-1:0] result,
    output logic              rd_write,
    output logic [3:0]        flags_out,
    output logic              flags_write
);

    alu_op_e           op;
    alu_flags_t        cur_flags;
    alu_flags_t        nxt_flags;
    logic [DATA_W-1:0] add_x, add_y, add_sum, logic_res, res_d;
    logic              add_cin, add_cout, add_ovf, flag_upd;

    assign op        = alu_op_e'(opcode);
    assign cur_flags = alu_flags_t'(flags_in);

    dp_alu_operands #(.DATA_W(DATA_W)) operands_i (
        .op        (op),
        .rn        (rn_val),
        .opnd      (shift_val),
        .c_flag    (cur_flags.c),
        .add_x     (add_x),
        .add_y     (add_y),
        .add_cin   (add_cin),
        .logic_res (logic_res)
    );

    dp_alu_adder #(.DATA_W(DATA_W)) adder_i (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    // Result selection between adder and bitwise paths
    always_comb res_d = op_is_arith(op) ? add_sum : logic_res;

    dp_alu_flags #(.DATA_W(DATA_W)) flags_i (
        .op       (op),
        .set_req  (set_flags),
        .res      (res_d),
        .add_cout (add_cout),
        .add_ovf  (add_ovf),
        .sh_carry (shift_carry),
        .cur      (cur_flags),
        .nxt      (nxt_flags),
        .upd      (flag_upd)
    );

    // Output register stage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result      <= '0;
            rd_write    <= 1'b0;
            flags_out   <= '0;
            flags_write <= 1'b0;
        end else begin
            result      <= res_d;
            rd_write    <= !op_is_compare(op);
            flags_out   <= nxt_flags;
            flags_write <= flag_upd;
        end
    end

endmodule

// File: rtl/dp_alu_checker.sv
// Property checker for dp_alu, attached by bind. Relates registered outputs
// to the inputs sampled one edge earlier.
module dp_alu_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        opcode,
    input logic              set_flags,
    input logic [DATA_W-1:0] rn_val,
    input logic [DATA_W-1:0] shift_val,
    input logic              shift_carry,
    input logic [3:0]        flags_in,
    input logic [DATA_W-1:0] result,
    input logic              rd_write,
    input logic [3:0]        flags_out,
    input logic              flags_write
);

    // R7: compares never write the destination and always update flags
    a_r7_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode[3:2]) == 2'b10) |-> (!rd_write && flags_write));

    // R12: no update request outside compares leaves flags untouched
    a_r12_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(set_flags) && $past(opcode[3:2]) != 2'b10)
        |-> (!flags_write && flags_out == $past(flags_in)));

    // R8: zero flag tracks an all-zero result when updated
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && flags_write) |-> (flags_out[2] == (result == '0)));

    // R8: negative flag tracks the result MSB when updated
    a_r8_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && flags_write) |-> (flags_out[3] == result[DATA_W-1]));

    // R11: logical operations take C from the shifter and keep V
    a_r11_logic_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(set_flags) &&
         ($past(opcode) inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15}))
        |-> (flags_out[1] == $past(shift_carry) && flags_out[0] == $past(flags_in[0])));

    // R4: moves are independent of the first operand
    a_r4_move_value: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == 4'd13) |-> (result == $past(shift_val)));

endmodule

bind dp_alu dp_alu_checker #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/dp_alu_tb_top.sv
// Sweep bench: 4-bit datapath, every opcode, operand pair, carry,
// set-flags value and shifter carry, with arithmetic reference values.
module dp_alu_tb_top;

    localparam int W = 4;
    localparam int M = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   opcode = '0;
    logic         set_flags = 1'b0;
    logic [W-1:0] rn_val = '0;
    logic [W-1:0] shift_val = '0;
    logic         shift_carry = 1'b0;
    logic [3:0]   flags_in = '0;
    logic [W-1:0] result;
    logic         rd_write;
    logic [3:0]   flags_out;
    logic         flags_write;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    dp_alu #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .set_flags(set_flags),
        .rn_val(rn_val), .shift_val(shift_val), .shift_carry(shift_carry),
        .flags_in(flags_in), .result(result), .rd_write(rd_write),
        .flags_out(flags_out), .flags_write(flags_write)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (op=%0d rn=%0h b=%0h fl=%0h s=%0b shc=%0b)",
                     tag, act, exp, opcode, rn_val, shift_val, flags_in, set_flags, shift_carry);
        end
    endtask

    // Reference model written from the requirement text
    task automatic expect_vals(output int e_res, output int e_rdw,
                               output int e_fl, output int e_fw);
        int  a, b, c, x, y, ci, sum, n, z, cf, vf;
        bit  arith, cmp;
        a = int'(rn_val); b = int'(shift_val); c = int'(flags_in[1]);
        arith = 1'b1; x = a; y = b; ci = 0;
        e_res = 0;
        case (opcode)
            4'd0, 4'd8:  begin arith = 0; e_res = a & b; end       // R3 / R7
            4'd1, 4'd9:  begin arith = 0; e_res = a ^ b; end
            4'd12:       begin arith = 0; e_res = a | b; end
            4'd13:       begin arith = 0; e_res = b; end            // R4
            4'd14:       begin arith = 0; e_res = a & (~b & M); end
            4'd15:       begin arith = 0; e_res = ~b & M; end
            4'd2, 4'd10: begin x = a; y = ~b & M; ci = 1; end       // R6
            4'd3:        begin x = b; y = ~a & M; ci = 1; end
            4'd4, 4'd11: begin x = a; y = b; ci = 0; end            // R5
            4'd5:        begin x = a; y = b; ci = c; end
            4'd6:        begin x = a; y = ~b & M; ci = c; end
            default:     begin x = b; y = ~a & M; ci = c; end
        endcase
        cmp = (opcode >= 8 && opcode <= 11);
        cf = int'(flags_in[1]); vf = int'(flags_in[0]);
        if (arith) begin
            sum   = x + y + ci;
            e_res = sum & M;
            cf    = (sum > M) ? 1 : 0;                              // R9
            vf    = (((x >> (W-1)) & 1) == ((y >> (W-1)) & 1) &&
                     ((e_res >> (W-1)) & 1) != ((x >> (W-1)) & 1)) ? 1 : 0; // R10
        end else begin
            cf = int'(shift_carry);                                 // R11
        end
        n = (e_res >> (W-1)) & 1;
        z = (e_res == 0) ? 1 : 0;
        e_rdw = cmp ? 0 : 1;
        e_fw  = (cmp || set_flags) ? 1 : 0;
        e_fl  = e_fw ? ((n << 3) | (z << 2) | (cf << 1) | vf) : int'(flags_in); // R12
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int e_res, e_rdw, e_fl, e_fw;
        string rtag;
        // R1: drive non-zero inputs during reset; outputs must stay clear
        opcode = 4'd15; set_flags = 1'b1; shift_val = '0; flags_in = 4'hF;
        repeat (3) @(negedge clk);
        check("R1 result", int'(result), 0);
        check("R1 rd_write", int'(rd_write), 0);
        check("R1 flags_out", int'(flags_out), 0);
        check("R1 flags_write", int'(flags_write), 0);
        rst_n = 1'b1;
        for (int op = 0; op < 16; op++)
            for (int a = 0; a <= M; a++)
                for (int b = 0; b <= M; b++)
                    for (int k = 0; k < 8; k++) begin
                        opcode      = 4'(op);
                        rn_val      = W'(a);
                        shift_val   = W'(b);
                        flags_in    = {1'b0, 1'b0, k[0], k[0] ^ k[1]};
                        set_flags   = k[1];
                        shift_carry = k[2];
                        expect_vals(e_res, e_rdw, e_fl, e_fw);
                        // R2: sample one edge after the inputs were applied
                        @(negedge clk);
                        if (op == 13 || op == 15)              rtag = "R2 R4 result";
                        else if (op inside {2, 3, 6, 7, 10})   rtag = "R2 R6 result";
                        else if (op inside {4, 5, 11})         rtag = "R2 R5 result";
                        else                                   rtag = "R2 R3 result";
                        check(rtag, int'(result), e_res);
                        check("R7 rd_write", int'(rd_write), e_rdw);
                        check("R7 R12 flags_write", int'(flags_write), e_fw);
                        check("R8 R9 R10 R11 R12 flags_out", int'(flags_out), e_fl);
                    end
        // R1: a mid-run reset clears outputs again
        opcode = 4'd13; shift_val = W'(M); set_flags = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R1 result after reassert", int'(result), 0);
        check("R1 flags_write after reassert", int'(flags_write), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule